// File: doc/BRIEF.md
# Program Loading Sequencer

This block is the control state machine that governs how a small processor fills its instruction store before it starts executing. After a restart it holds the program counter in its cleared state for one cycle. It then loops over one stored byte at a time, using a fixed train of one-cycle control pulses. Each byte takes a low-nibble capture, a high-nibble capture, a snapshot of the program counter into the adder buffer, and a settle window while the adder resolves. Then comes the memory write at the current counter value, and finally the counter increment.

At the end of every byte the block looks at the load-done flag raised by the counter-check logic. If the flag is low, the next byte starts. If it is high, the block enters its running phase and holds there. In the running phase every load pulse is quiet and only the mode output is high. The branch-select output stays low, so the counter always advances by one while loading. Instruction decode in the running phase belongs to another block.

All pins are plain level control signals. There is no data stream, so no valid/ready handshake applies. Outputs are decoded from registered state only, so each pulse lasts exactly one clock.

Top module: `prog_load_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `restart` is sampled high on any clock edge, `pc_clear` is 1, `run_mode` is 0 and every other pulse output is 0.
- R2: The cycle after a `pc_clear` cycle with `restart` low, `buf_lo_en` is 1. The cycle after any `buf_lo_en` cycle with `restart` low, `buf_hi_en` is 1.
- R3: The cycle after a `buf_hi_en` cycle with `restart` low, `pc_buf_en` is 1.
- R4: After `pc_buf_en`, exactly `SETTLE_CYCLES` cycles (default 1) follow with every pulse output 0. Then `imem_wr` is 1 for one cycle.
- R5: The cycle after an `imem_wr` cycle with `restart` low, `pc_inc` is 1.
- R6: If `load_done` is 0 in a `pc_inc` cycle and `restart` is low, the next cycle has `buf_lo_en` at 1, which starts another byte.
- R7: If `load_done` is 1 in a `pc_inc` cycle and `restart` is low, `run_mode` becomes 1 the next cycle. It then stays 1 until `restart` or reset.
- R8: `load_done` has no effect in any cycle other than a `pc_inc` cycle.
- R9: `pc_branch` is 0 in every cycle.
- R10: At most one of the pulse outputs `pc_clear`, `buf_lo_en`, `buf_hi_en`, `pc_buf_en`, `imem_wr` and `pc_inc` is 1 in any cycle. All of them are 0 whenever `run_mode` is 1.
- R11: If `restart` and `load_done` are both 1 in a `pc_inc` cycle, `restart` wins: the next cycle has `pc_clear` at 1 and `run_mode` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart into loading |
| load_done | input | 1 | Counter-check flag meaning all locations are filled |
| pc_clear | output | 1 | Clear the program counter |
| buf_lo_en | output | 1 | Capture the low nibble of the byte |
| buf_hi_en | output | 1 | Capture the high nibble of the byte |
| pc_buf_en | output | 1 | Snapshot the program counter into the adder buffer |
| imem_wr | output | 1 | Write the assembled byte at the current counter value |
| pc_inc | output | 1 | Load the adder sum into the program counter |
| pc_branch | output | 1 | Adder operand select: 0 adds one, 1 adds the bus value |
| run_mode | output | 1 | Running phase active |

## Verification
Two events can land in the same cycle. One is a restart. The other is the end-of-byte decision, which either starts the next byte or moves to the running phase. The bench provokes the collision by raising `restart` and `load_done` together in a `pc_inc` cycle. It also raises `restart` in mid-byte and in the running phase. Each case is judged one cycle later: `pc_clear` must be high and `run_mode` low, then a fresh `buf_lo_en` must follow. A sequence that had already committed to the running phase, or that carried on with the interrupted byte, shows up directly in those outputs.

// File: rtl/prog_load_pkg.sv
package prog_load_pkg;
  typedef enum logic [2:0] {
    PH_CLEAR  = 3'd0,
    PH_LO     = 3'd1,
    PH_HI     = 3'd2,
    PH_PCBUF  = 3'd3,
    PH_SETTLE = 3'd4,
    PH_WRITE  = 3'd5,
    PH_INC    = 3'd6,
    PH_RUN    = 3'd7
  } phase_t;

  localparam int NUM_PULSES = 6;

  // pulse vector bit positions
  localparam int P_CLEAR = 0;
  localparam int P_LO    = 1;
  localparam int P_HI    = 2;
  localparam int P_PCBUF = 3;
  localparam int P_WRITE = 4;
  localparam int P_INC   = 5;
endpackage

// File: rtl/prog_load_settle.sv
module prog_load_settle #(
  parameter int SETTLE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW   = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
  localparam int LAST = (SETTLE_CYCLES < 1) ? 0 : SETTLE_CYCLES - 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign done = active && (cnt_q == CW'(LAST));
endmodule

// File: rtl/prog_load_fsm.sv
module prog_load_fsm
  import prog_load_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   load_done,
  input  logic   settle_done,
  output phase_t phase
);
  phase_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    unique case (cur_q)
      PH_CLEAR:  nxt = PH_LO;
      PH_LO:     nxt = PH_HI;
      PH_HI:     nxt = PH_PCBUF;
      PH_PCBUF:  nxt = PH_SETTLE;
      PH_SETTLE: nxt = settle_done ? PH_WRITE : PH_SETTLE;
      PH_WRITE:  nxt = PH_INC;
      PH_INC:    nxt = load_done ? PH_RUN : PH_LO;
      PH_RUN:    nxt = PH_RUN;
      default:   nxt = PH_CLEAR;
    endcase
    if (restart) nxt = PH_CLEAR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= PH_CLEAR;
    else        cur_q <= nxt;
  end

  assign phase = cur_q;
endmodule

// File: rtl/prog_load_strobes.sv
module prog_load_strobes
  import prog_load_pkg::*;
(
  input  phase_t                phase,
  output logic [NUM_PULSES-1:0] pulses,
  output logic                  running
);
  // phase code for each pulse bit, in pulse-bit order
  localparam logic [3*NUM_PULSES-1:0] PULSE_PHASE = {
    3'(PH_INC), 3'(PH_WRITE), 3'(PH_PCBUF), 3'(PH_HI), 3'(PH_LO), 3'(PH_CLEAR)
  };

  for (genvar i = 0; i < NUM_PULSES; i++) begin : g_pulse
    assign pulses[i] = (phase == phase_t'(PULSE_PHASE[3*i +: 3]));
  end

  assign running = (phase == PH_RUN);
endmodule

// File: rtl/prog_load_seq.sv
module prog_load_seq
  import prog_load_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic load_done,
  output logic pc_clear,
  output logic buf_lo_en,
  output logic buf_hi_en,
  output logic pc_buf_en,
  output logic imem_wr,
  output logic pc_inc,
  output logic pc_branch,
  output logic run_mode
);
  phase_t                phase;
  logic                  settle_done;
  logic [NUM_PULSES-1:0] pulses;
  logic                  running;

  prog_load_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .load_done   (load_done),
    .settle_done (settle_done),
    .phase       (phase)
  );

  prog_load_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (phase == PH_SETTLE),
    .done   (settle_done)
  );

  prog_load_strobes u_strobes (
    .phase   (phase),
    .pulses  (pulses),
    .running (running)
  );

  assign pc_clear  = pulses[P_CLEAR];
  assign buf_lo_en = pulses[P_LO];
  assign buf_hi_en = pulses[P_HI];
  assign pc_buf_en = pulses[P_PCBUF];
  assign imem_wr   = pulses[P_WRITE];
  assign pc_inc    = pulses[P_INC];
  assign pc_branch = 1'b0;
  assign run_mode  = running;
endmodule

// File: rtl/prog_load_seq_chk.sv
module prog_load_seq_chk #(
  parameter int SETTLE_CYCLES = 1
) (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic load_done,
  input logic pc_clear,
  input logic buf_lo_en,
  input logic buf_hi_en,
  input logic pc_buf_en,
  input logic imem_wr,
  input logic pc_inc,
  input logic pc_branch,
  input logic run_mode
);
  localparam int GW = $clog2(SETTLE_CYCLES + 2) + 1;

  logic [5:0]    pv;
  logic [GW-1:0] gap_q;
  assign pv = {pc_inc, imem_wr, pc_buf_en, pc_buf_en & 1'b0 | buf_hi_en, buf_lo_en, pc_clear};

  // counts pulse-free loading cycles since the last adder-buffer snapshot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (pc_buf_en) gap_q <= '0;
    else if (pv == '0 && !run_mode && gap_q != '1) gap_q <= gap_q + 1'b1;
  end

  assert_clear_after_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pc_clear && !run_mode);
  assert_lo_after_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_clear && !restart |=> buf_lo_en);
  assert_hi_after_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    buf_lo_en && !restart |=> buf_hi_en);
  assert_pcbuf_after_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_hi_en && !restart |=> pc_buf_en);
  assert_settle_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    imem_wr |-> gap_q == GW'(SETTLE_CYCLES));
  assert_inc_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    imem_wr && !restart |=> pc_inc);
  assert_next_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc && !load_done && !restart |=> buf_lo_en);
  assert_enter_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc && load_done && !restart |=> run_mode);
  assert_hold_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_mode && !restart |=> run_mode);
  assert_no_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_branch);
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pv));
  assert_quiet_in_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_mode |-> pv == '0);
  assert_restart_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc && load_done && restart |=> !run_mode);
endmodule

bind prog_load_seq prog_load_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .restart   (restart),
  .load_done (load_done),
  .pc_clear  (pc_clear),
  .buf_lo_en (buf_lo_en),
  .buf_hi_en (buf_hi_en),
  .pc_buf_en (pc_buf_en),
  .imem_wr   (imem_wr),
  .pc_inc    (pc_inc),
  .pc_branch (pc_branch),
  .run_mode  (run_mode)
);

// File: tb/prog_load_seq_bench.sv
module prog_load_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic load_done = 1'b0;
  logic pc_clear, buf_lo_en, buf_hi_en, pc_buf_en, imem_wr, pc_inc, pc_branch, run_mode;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  prog_load_seq u_prog_load_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart), .load_done(load_done),
    .pc_clear(pc_clear), .buf_lo_en(buf_lo_en), .buf_hi_en(buf_hi_en),
    .pc_buf_en(pc_buf_en), .imem_wr(imem_wr), .pc_inc(pc_inc),
    .pc_branch(pc_branch), .run_mode(run_mode)
  );

  // output vector: {run_mode, pc_branch, pc_inc, imem_wr, pc_buf_en, buf_hi_en, buf_lo_en, pc_clear}
  function automatic logic [7:0] outs();
    return {run_mode, pc_branch, pc_inc, imem_wr, pc_buf_en, buf_hi_en, buf_lo_en, pc_clear};
  endfunction

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: outputs actual %08b expected %08b at %0t", req, act, exp, $time);
    end
  endtask

  // vector: {req[3:0], restart, load_done, expected outs[7:0]}; expected is seen in the
  // cycle the inputs are applied, inputs act at the following edge
  localparam int NV = 27;
  localparam logic [13:0] VEC [NV] = '{
    {4'd1,  2'b01, 8'h01}, // R1 clear after reset, load_done ignored (R8)
    {4'd2,  2'b01, 8'h02}, // R2 low nibble
    {4'd2,  2'b01, 8'h04}, // R2 high nibble
    {4'd3,  2'b01, 8'h08}, // R3 pc buffer
    {4'd4,  2'b01, 8'h00}, // R4 settle, R8 load_done has no effect
    {4'd4,  2'b01, 8'h10}, // R4 write
    {4'd5,  2'b00, 8'h20}, // R5 inc, load_done low
    {4'd6,  2'b00, 8'h02}, // R6 next byte
    {4'd2,  2'b00, 8'h04},
    {4'd3,  2'b00, 8'h08},
    {4'd4,  2'b00, 8'h00},
    {4'd4,  2'b00, 8'h10},
    {4'd5,  2'b01, 8'h20}, // R5 inc with load_done high
    {4'd7,  2'b00, 8'h80}, // R7 running
    {4'd10, 2'b01, 8'h80}, // R10 quiet in run
    {4'd7,  2'b10, 8'h80}, // R7 held; restart applied
    {4'd1,  2'b00, 8'h01}, // R1 clear after restart from run
    {4'd2,  2'b10, 8'h02}, // restart mid-byte
    {4'd1,  2'b00, 8'h01}, // R1
    {4'd2,  2'b00, 8'h02},
    {4'd2,  2'b00, 8'h04},
    {4'd3,  2'b00, 8'h08},
    {4'd4,  2'b00, 8'h00},
    {4'd4,  2'b00, 8'h10},
    {4'd11, 2'b11, 8'h20}, // R11 restart and load_done together
    {4'd11, 2'b00, 8'h01}, // R11 restart wins
    {4'd2,  2'b00, 8'h02}
  };

  initial begin
    repeat (3) @(negedge clk);
    check(1, outs(), 8'h01); // R1 state during reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      check(int'(VEC[i][13:10]), outs(), VEC[i][7:0]);
      restart   = VEC[i][9];
      load_done = VEC[i][8];
      @(negedge clk);
    end
    restart = 1'b0;
    load_done = 1'b0;
    // now in high-nibble phase; async reset mid-byte (R1)
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(1, outs(), 8'h01);
    @(negedge clk);
    // R7/R8: load_done held high from the start gives exactly one byte then run
    rst_n = 1'b1;
    load_done = 1'b1;
    begin
      int writes = 0;
      for (int c = 0; c < 7; c++) begin
        if (imem_wr) writes++;
        check(9, {7'd0, pc_branch}, 8'h00); // R9 branch select stays low
        if (run_mode) check(8, 8'h80, 8'h00); // R8 must not run early
        @(negedge clk);
      end
      check(8, 8'(writes), 8'd1);
      check(7, outs(), 8'h80);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule